// File: doc/BRIEF.md
# Float to Signed 32-bit Integer Converter (Truncating)

This block turns an unpacked floating-point operand into a signed two's-complement integer of 32 bits. The operand arrives already split into a class code, a sign bit, an unbiased signed exponent and a mantissa whose most significant bit is the explicit leading one, followed by lower fraction bits (guard and round included) and a separate sticky bit that summarises anything already discarded upstream. The conversion always chops toward zero. No rounding mode takes part in it.

Inside, an aligner shifts the mantissa right so that the integer part lands in the low 32 bits, and it collects every bit it pushes out. A packing stage then decides whether the value fits. Fitting values are negated when the sign is set and flagged inexact if anything was dropped. Values that do not fit, and infinities and NaNs, saturate to the sign-dependent limit with only the invalid flag raised. The result, both flags and a valid strobe are registered, so the latency is one clock.

Top module: `fp2int_trunc`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_int, out_inexact and out_invalid are all 0. out_valid equals in_valid of the previous cycle, and results appear one clock after the operand.
- R2: Class code 0 (zero) gives out_int = 0 with both flags clear, whatever the sign, exponent and mantissa.
- R3: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN), and the unused codes 5 to 7, give overflow. That is out_int = 0x7FFFFFFF when the sign is 0 and 0x80000000 when the sign is 1, with out_invalid = 1 and out_inexact = 0.
- R4: Class code 1 (number) with an exponent of 32 or more gives the same overflow output as R3.
- R5: For class 1, the value is in_mant × 2^(in_exp − (MANT_W−1)), where bit MANT_W−1 of in_mant has weight 2^0. The magnitude produced is that value with its fraction dropped (truncation toward zero).
- R6: For a class-1 result that does not overflow, out_inexact is 1 exactly when a nonzero mantissa bit was shifted out or in_sticky is 1. out_invalid is then 0.
- R7: Overflow occurs when the magnitude is at least 0x80000000 + sign. A positive magnitude of 0x80000000 overflows. A negative magnitude of exactly 0x80000000 gives 0x80000000 with no invalid flag. A negative magnitude above that overflows.
- R8: A non-overflowing negative operand yields the two's complement of its magnitude.
- R9: When the shift reaches the full mantissa width (any negative exponent at default widths), the magnitude is 0 and out_inexact reflects whether any mantissa bit or in_sticky was nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W (16) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (40) | Mantissa, explicit leading one at the top bit |
| in_sticky | input | 1 | OR of bits already discarded below the mantissa |
| out_valid | output | 1 | Result valid |
| out_int | output | INT_W (32) | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Operand did not fit or was not a number |

## Verification
Assertions check, on every cycle, the one-cycle valid timing, the zero-class output and the saturation pattern for special classes and large exponents. They also check the sign of the result against the operand sign, that invalid and inexact never appear together, and that the aligner returns zero for negative exponents. Exact magnitudes after truncation depend on the operand, and only the bench's vectors show them. The same holds for the asymmetric edge at magnitude 0x80000000 with and without discarded bits, for sticky-only inexact and for reset clearing the outputs mid-stream.

// File: rtl/fp2int_pkg.sv
// fp2int_pkg: shared class codes for the float-to-integer converter.
// Assumes a 3-bit class field; codes 5 to 7 are not defined by this type.
package fp2int_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fcls_e;

endpackage

// File: rtl/fp2int_align.sv
// fp2int_align: shifts the mantissa right so the integer part sits in the
// low INT_W bits, and reports whether any nonzero bit was pushed out.
// Assumes MANT_W > INT_W and the leading one at bit MANT_W-1 (weight 2^0).
// Exponents of INT_W or more are flagged as over-range and not shifted.
module fp2int_align #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 16,
    parameter int INT_W  = 32
) (
    input  logic signed [EXP_W-1:0]  exp_i,
    input  logic        [MANT_W-1:0] mant_i,
    output logic                     over_exp_o,
    output logic                     hi_nz_o,
    output logic        [INT_W-1:0]  mag_o,
    output logic                     lost_o
);
    localparam int SH_W = $clog2(MANT_W);
    localparam int XW   = EXP_W + 2;
    localparam logic signed [XW-1:0]    TOP_POS = XW'(MANT_W - 1);
    localparam logic signed [XW-1:0]    FAR_LIM = XW'(MANT_W);
    localparam logic signed [EXP_W-1:0] OVF_EXP = EXP_W'(INT_W);

    logic signed [XW-1:0] exp_x;
    logic signed [XW-1:0] sh_full;
    logic                 far;
    logic [SH_W-1:0]      amt;

    logic [MANT_W-1:0] st    [SH_W+1];
    logic              lo_st [SH_W+1];

    // Shift distance and range decisions.
    always_comb begin
        exp_x      = {{2{exp_i[EXP_W-1]}}, exp_i};
        sh_full    = TOP_POS - exp_x;
        over_exp_o = (exp_i >= OVF_EXP);
        far        = (sh_full >= FAR_LIM);
        amt        = sh_full[SH_W-1:0];
    end

    assign st[0]    = mant_i;
    assign lo_st[0] = 1'b0;

    // Logarithmic shifter; each stage gathers the bits it discards.
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign st[k+1]    = amt[k] ? (st[k] >> STEP) : st[k];
        assign lo_st[k+1] = lo_st[k] | (amt[k] & (|st[k][STEP-1:0]));
    end

    // Output selection for in-range, far and over-range exponents.
    always_comb begin
        if (over_exp_o || far) begin
            mag_o   = '0;
            hi_nz_o = 1'b0;
        end else begin
            mag_o   = st[SH_W][INT_W-1:0];
            hi_nz_o = |st[SH_W][MANT_W-1:INT_W];
        end
        lost_o = far ? (|mant_i) : lo_st[SH_W];
    end

endmodule

// File: rtl/fp2int_pack.sv
// fp2int_pack: decides overflow from class, exponent range and magnitude,
// then forms the signed result and the inexact and invalid flags.
// Assumes the magnitude comes from fp2int_align with the same INT_W.
module fp2int_pack
    import fp2int_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [2:0]       cls_i,
    input  logic             sign_i,
    input  logic             over_exp_i,
    input  logic             hi_nz_i,
    input  logic [INT_W-1:0] mag_i,
    input  logic             lost_i,
    input  logic             sticky_i,
    output logic [INT_W-1:0] res_o,
    output logic             nx_o,
    output logic             nv_o
);
    localparam logic [INT_W-1:0] MIN_MAG = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {INT_W-1{1'b1}}};

    logic             is_zero;
    logic             is_num;
    logic [INT_W-1:0] thr;
    logic             ovf;

    // Class decode and sign-dependent overflow limit.
    always_comb begin
        is_zero = (cls_i == CLS_ZERO);
        is_num  = (cls_i == CLS_NUM);
        thr     = MIN_MAG + INT_W'(sign_i);
        ovf     = !is_zero &&
                  (!is_num || over_exp_i || hi_nz_i || (mag_i >= thr));
    end

    // Result and flags; overflow saturates and reports only invalid.
    always_comb begin
        if (is_zero) begin
            res_o = '0;
        end else if (ovf) begin
            res_o = SAT_POS + INT_W'(sign_i);
        end else if (sign_i) begin
            res_o = (~mag_i) + INT_W'(1);
        end else begin
            res_o = mag_i;
        end
        nv_o = ovf;
        nx_o = is_num && !ovf && (lost_i || sticky_i);
    end

endmodule

// File: rtl/fp2int_trunc.sv
// fp2int_trunc: top of the truncating float-to-integer converter.
// Combinational align and pack, followed by one output register stage.
// Assumes MANT_W > INT_W; synchronous active-low reset clears all outputs.
module fp2int_trunc
    import fp2int_pkg::*;
#(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 16,
    parameter int INT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic                    in_sticky,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_int,
    output logic                    out_inexact,
    output logic                    out_invalid
);
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {INT_W-1{1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {INT_W-1{1'b0}}};
    localparam logic signed [EXP_W-1:0] OVF_EXP = EXP_W'(INT_W);

    logic             a_over;
    logic             a_hi_nz;
    logic [INT_W-1:0] a_mag;
    logic             a_lost;
    logic [INT_W-1:0] p_res;
    logic             p_nx;
    logic             p_nv;

    fp2int_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_align (
        .exp_i      (in_exp),
        .mant_i     (in_mant),
        .over_exp_o (a_over),
        .hi_nz_o    (a_hi_nz),
        .mag_o      (a_mag),
        .lost_o     (a_lost)
    );

    fp2int_pack #(.INT_W(INT_W)) u_pack (
        .cls_i      (in_class),
        .sign_i     (in_sign),
        .over_exp_i (a_over),
        .hi_nz_i    (a_hi_nz),
        .mag_i      (a_mag),
        .lost_i     (a_lost),
        .sticky_i   (in_sticky),
        .res_o      (p_res),
        .nx_o       (p_nx),
        .nv_o       (p_nv)
    );

    // Output register: one-cycle latency, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_int     <= p_res;
            out_inexact <= p_nx;
            out_invalid <= p_nv;
        end
    end

    // R1: valid follows the input strobe by exactly one cycle.
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: zero class gives a clean zero.
    a_r2_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_ZERO)
        |=> (out_int == '0 && !out_inexact && !out_invalid));

    // R3: non-number classes saturate by sign with only invalid set.
    a_r3_special_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class != CLS_ZERO && in_class != CLS_NUM)
        |=> (out_invalid && !out_inexact &&
             out_int == ($past(in_sign) ? SAT_NEG : SAT_POS)));

    // R4: large exponent on a number is always invalid.
    a_r4_big_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_NUM && in_exp >= OVF_EXP)
        |=> out_invalid);

    // R3: invalid and inexact never appear together.
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> !out_inexact);

    // R7: positive operands never give a result with the top bit set unless saturated.
    a_r7_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_NUM && !in_sign)
        |=> (out_invalid || !out_int[INT_W-1]));

    // R8: negative numbers give zero or a negative result.
    a_r8_neg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_NUM && in_sign)
        |=> (out_invalid || out_int == '0 || out_int[INT_W-1]));

    // R6: an all-zero mantissa without sticky is never inexact.
    a_r6_exact_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_NUM && in_mant == '0 && !in_sticky)
        |=> !out_inexact);

    // R9: negative exponents leave no integer part in the aligner.
    a_r9_frac_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exp[EXP_W-1]) |-> (a_mag == '0 && !a_hi_nz));

endmodule

// File: tb/fp2int_trunc_tb.sv
module fp2int_trunc_tb;
    localparam int MANT_W = 40;
    localparam int EXP_W  = 16;
    localparam int INT_W  = 32;
    localparam int VW     = 3 + 1 + EXP_W + MANT_W + 1 + INT_W + 2;
    localparam int NV     = 22;

    // {class, sign, exp, mant, sticky, expected int, expected nx, expected nv}
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd1, 1'b0, 16'h0000, 40'h8000000000, 1'b0, 32'h00000001, 1'b0, 1'b0}, // R5 1.0
        {3'd1, 1'b0, 16'h0001, 40'hB800000000, 1'b0, 32'h00000002, 1'b1, 1'b0}, // R5 2.875
        {3'd1, 1'b1, 16'h0001, 40'hB800000000, 1'b0, 32'hFFFFFFFE, 1'b1, 1'b0}, // R8 -2.875
        {3'd1, 1'b0, 16'h001F, 40'h8000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1}, // R7 +2^31
        {3'd1, 1'b1, 16'h001F, 40'h8000000000, 1'b0, 32'h80000000, 1'b0, 1'b0}, // R7 -2^31
        {3'd1, 1'b1, 16'h001F, 40'h8000000002, 1'b0, 32'h80000000, 1'b1, 1'b0}, // R7 -2^31 lost
        {3'd1, 1'b1, 16'h001F, 40'h8000000100, 1'b0, 32'h80000000, 1'b0, 1'b1}, // R7 -(2^31+1)
        {3'd1, 1'b0, 16'h001E, 40'hFFFFFFFFFF, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0}, // R6 max positive
        {3'd1, 1'b0, 16'h0020, 40'h8000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1}, // R4 exp 32
        {3'd1, 1'b0, 16'hFFFF, 40'h8000000000, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R9 0.5
        {3'd1, 1'b1, 16'hFFFF, 40'h8000000000, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R9 -0.5
        {3'd1, 1'b0, 16'hFF9C, 40'h8000000000, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R9 exp -100
        {3'd1, 1'b0, 16'h0005, 40'h8000000000, 1'b1, 32'h00000020, 1'b1, 1'b0}, // R6 sticky only
        {3'd1, 1'b0, 16'h0005, 40'h8400000000, 1'b0, 32'h00000021, 1'b0, 1'b0}, // R5 33 exact
        {3'd0, 1'b1, 16'h0032, 40'hFFFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 1'b0}, // R2 zero
        {3'd2, 1'b0, 16'h0000, 40'h8000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1}, // R3 +inf
        {3'd3, 1'b1, 16'h0000, 40'hC000000000, 1'b1, 32'h80000000, 1'b0, 1'b1}, // R3 -qnan
        {3'd4, 1'b0, 16'h0000, 40'hA000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1}, // R3 snan
        {3'd7, 1'b1, 16'h0003, 40'h8000000000, 1'b0, 32'h80000000, 1'b0, 1'b1}, // R3 code 7
        {3'd1, 1'b0, 16'hFFFD, 40'h0000000000, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R6 zero mant
        {3'd1, 1'b1, 16'h0027, 40'h8000000000, 1'b0, 32'h80000000, 1'b0, 1'b1}, // R4 exp 39
        {3'd1, 1'b1, 16'h0010, 40'h8000000000, 1'b0, 32'hFFFF0000, 1'b0, 1'b0}  // R8 -65536
    };

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    in_valid;
    logic [2:0]              in_class;
    logic                    in_sign;
    logic signed [EXP_W-1:0] in_exp;
    logic [MANT_W-1:0]       in_mant;
    logic                    in_sticky;
    logic                    out_valid;
    logic [INT_W-1:0]        out_int;
    logic                    out_inexact;
    logic                    out_invalid;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fp2int_trunc #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_dut (
        .clk, .rst_n, .in_valid, .in_class, .in_sign, .in_exp,
        .in_mant, .in_sticky, .out_valid, .out_int, .out_inexact, .out_invalid
    );

    function automatic string req_of(int idx);
        case (idx)
            0, 1, 13:          return "R5";
            2, 21:             return "R8";
            3, 4, 5, 6:        return "R7";
            7, 12, 19:         return "R6";
            8, 20:             return "R4";
            9, 10, 11:         return "R9";
            14:                return "R2";
            default:           return "R3";
        endcase
    endfunction

    task automatic check(string req, logic [INT_W+2:0] act, logic [INT_W+2:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: got valid/int/nx/nv=%h expected %h", req, act, exp_v);
        end
    endtask

    task automatic drive(logic [VW-1:0] v);
        {in_class, in_sign, in_exp, in_mant, in_sticky} = v[VW-1:INT_W+2];
        in_valid = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_class = 3'd0; in_sign = 1'b0;
        in_exp = '0; in_mant = '0; in_sticky = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_int, out_inexact, out_invalid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_int, out_inexact, out_invalid}, '0);

        // Vector table, one operand per cycle, sampled one clock later.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(req_of(i), {out_valid, out_int, out_inexact, out_invalid},
                  {1'b1, VEC[i][INT_W+1:0]});
        end

        // R1: valid drops one cycle after the strobe does.
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", {32'b0, out_valid}, 33'b0);

        // R1: reset in the middle of a stream clears the outputs.
        drive(VEC[3]);
        @(negedge clk);
        check("R1", {out_valid, out_int, out_inexact, out_invalid}, {1'b1, 32'h7FFFFFFF, 2'b01});
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, out_int, out_inexact, out_invalid}, '0);
        rst_n = 1'b1;
        drive(VEC[5]);
        @(negedge clk);
        check("R7", {out_valid, out_int, out_inexact, out_invalid}, {1'b1, 32'h80000000, 2'b10});
        in_valid = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule